// File: doc/BRIEF.md
# CCD Line Region Timing Sequencer

This block follows the readout position of a CCD frame, one pixel per clock, and chooses for every line which horizontal timing sequence applies: a blanking sequence for lines outside the read region, an optical-black sequence for the black rows above and below the picture, or an image sequence for the picture rows. From that choice and the pixel position within the line it drives four active-low strobes for the analog front end. `hblk_n` blanks the horizontal interval. `pblk_n` blanks the pixel data. `clpob_n` clamps to the black level. `clpdm_n` clamps on the dummy pixels. It also reports a 2-bit code for the sequence in force.

A frame-start pulse opens line 0. Each line-start pulse opens the next line. Region sizes come from configuration inputs. A typical sensor has 28 dummy pixels at the start of every line, 10 black rows before the picture and 2 after it, and 48 trailing black pixels on each picture line. Two mode bits choose whether blanking lines hold `pblk_n` low for the whole line and whether they pulse `clpdm_n` over the dummy pixels. That second mode keeps the input clamp settled when the horizontal clocks keep running during blanking.

No data stream passes through the block: every pin is a plain control or status level, with no valid/ready handshake and no back-pressure.

Top module: `ccd_line_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, and from reset until the first `frame_start`, all four strobes are high (inactive) and `seq_code` is 2'b00.
- R2: `frame_start` sets the position to line 0, pixel 0, and takes priority over a `line_start` in the same cycle. `line_start` moves to pixel 0 of the next line. Any other cycle advances the pixel index by one. The strobes and `seq_code` for a position appear in the cycle right after the clock edge that samples the pulse that set up that position.
- R3: With VB, FO, AC and BO the blanking, front black, image and back black line counts, lines are ordered as follows. Lines 0 to VB-1 are blanking, with `seq_code` 2'b00. The next FO lines are black, with 2'b01. The next AC lines are image, with 2'b10. The next BO lines are black, with 2'b01. All later lines are blanking until the next frame. Code 2'b11 never appears.
- R4: In every sequence, `hblk_n` is low when the pixel index p is below the dummy count D or at or beyond the line length L, and high otherwise.
- R5: In blanking lines `clpob_n` stays high.
- R6: In blanking lines `clpdm_n` is low for p < D only when `cfg_blank_clpdm` is 1. Otherwise it stays high.
- R7: In blanking lines with `cfg_blank_pblk` = 1, `pblk_n` is low for the whole line. In all other cases `pblk_n` equals `hblk_n`.
- R8: In black lines `clpob_n` and `clpdm_n` are both low for every p < L and high for p >= L.
- R9: In image lines `clpob_n` and `clpdm_n` are both low only for L-T <= p < L, where T is the trailing black count. They are high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Opens line 0 of a new frame |
| line_start | input | 1 | Opens the next line |
| cfg_dummy_px | input | PIX_W | Dummy pixels at the start of each line (D) |
| cfg_line_px | input | PIX_W | Pixels per line (L) |
| cfg_tail_ob_px | input | PIX_W | Trailing black pixels on image lines (T) |
| cfg_vblank_lines | input | LINE_W | Blanking lines before the read region (VB) |
| cfg_front_ob_lines | input | LINE_W | Black lines before the picture (FO) |
| cfg_active_lines | input | LINE_W | Picture lines (AC) |
| cfg_back_ob_lines | input | LINE_W | Black lines after the picture (BO) |
| cfg_blank_clpdm | input | 1 | Pulse dummy clamp over dummy pixels in blanking lines |
| cfg_blank_pblk | input | 1 | Hold pixel blanking over whole blanking lines |
| hblk_n | output | 1 | Horizontal blanking strobe, active low |
| pblk_n | output | 1 | Pixel blanking strobe, active low |
| clpob_n | output | 1 | Black-level clamp strobe, active low |
| clpdm_n | output | 1 | Dummy clamp strobe, active low |
| seq_code | output | 2 | Active sequence: 00 blanking, 01 black, 10 image |

## Verification
The assertions assume that the configuration inputs hold steady while a frame is being read, that T does not exceed L - D, and that pixel and line indices stay below their saturation values. The stimulus changes configuration only between frames, right before a `frame_start`. It uses small line lengths and line counts that keep every index far below saturation. One line in each frame runs a few cycles past L, so the strobe behaviour beyond the end of the line is exercised without leaving these bounds.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_BLANK = 2'b00,
    SEQ_OB    = 2'b01,
    SEQ_IMAGE = 2'b10
  } seq_e;
endpackage

// File: rtl/ccd_pos_counter.sv
module ccd_pos_counter #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  output logic [PIX_W-1:0]  px_nxt,
  output logic [LINE_W-1:0] line_nxt,
  output logic              seen_nxt
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = {PIX_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [PIX_W-1:0]  px_q;
  logic [LINE_W-1:0] line_q;
  logic              seen_q;

  always_comb begin
    px_nxt   = px_q;
    line_nxt = line_q;
    seen_nxt = seen_q;
    if (frame_start) begin
      px_nxt   = '0;
      line_nxt = '0;
      seen_nxt = 1'b1;
    end else if (line_start) begin
      px_nxt = '0;
      if (line_q != LINE_MAX) line_nxt = line_q + 1'b1;
    end else if (px_q != PIX_MAX) begin
      px_nxt = px_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_q   <= '0;
      line_q <= '0;
      seen_q <= 1'b0;
    end else begin
      px_q   <= px_nxt;
      line_q <= line_nxt;
      seen_q <= seen_nxt;
    end
  end

  assert_reset_pos_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (line_q == '0 && !seen_q));

  assert_frame_line0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (line_q == '0 && px_q == '0 && seen_q));

  assert_line_px0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (px_q == '0));
endmodule

// File: rtl/ccd_region_decode.sv
module ccd_region_decode
  import ccd_seq_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic [LINE_W-1:0] line_idx,
  input  logic              seen,
  input  logic [LINE_W-1:0] vblank_lines,
  input  logic [LINE_W-1:0] front_ob_lines,
  input  logic [LINE_W-1:0] active_lines,
  input  logic [LINE_W-1:0] back_ob_lines,
  output seq_e              seq
);
  localparam int SW = LINE_W + 2;

  logic [SW-1:0] edge_front, edge_image, edge_back, edge_end, line_x;

  always_comb begin
    line_x     = {2'b00, line_idx};
    edge_front = {2'b00, vblank_lines};
    edge_image = edge_front + {2'b00, front_ob_lines};
    edge_back  = edge_image + {2'b00, active_lines};
    edge_end   = edge_back + {2'b00, back_ob_lines};
    if (!seen)                   seq = SEQ_BLANK;
    else if (line_x < edge_front) seq = SEQ_BLANK;
    else if (line_x < edge_image) seq = SEQ_OB;
    else if (line_x < edge_back)  seq = SEQ_IMAGE;
    else if (line_x < edge_end)   seq = SEQ_OB;
    else                          seq = SEQ_BLANK;
  end
endmodule

// File: rtl/ccd_strobe_gen.sv
module ccd_strobe_gen
  import ccd_seq_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] px,
  input  logic             seen,
  input  seq_e             seq,
  input  logic [PIX_W-1:0] dummy_px,
  input  logic [PIX_W-1:0] line_px,
  input  logic [PIX_W-1:0] tail_px,
  input  logic             blank_clpdm,
  input  logic             blank_pblk,
  output logic             hblk_n,
  output logic             pblk_n,
  output logic             clpob_n,
  output logic             clpdm_n,
  output seq_e             seq_o
);
  localparam int XW = PIX_W + 1;

  logic          in_dummy, in_line, past_end, in_tail;
  logic          hb_on, pb_on, ob_on, dm_on;
  logic [XW-1:0] px_plus_tail;

  always_comb begin
    px_plus_tail = {1'b0, px} + {1'b0, tail_px};
    in_dummy = (px < dummy_px);
    in_line  = (px < line_px);
    past_end = !in_line;
    in_tail  = in_line && (px_plus_tail >= {1'b0, line_px});
    hb_on    = in_dummy || past_end;
    pb_on    = hb_on;
    ob_on    = 1'b0;
    dm_on    = 1'b0;
    unique case (seq)
      SEQ_BLANK: begin
        dm_on = blank_clpdm && in_dummy;
        pb_on = blank_pblk || hb_on;
      end
      SEQ_OB: begin
        ob_on = in_line;
        dm_on = in_line;
      end
      SEQ_IMAGE: begin
        ob_on = in_tail;
        dm_on = in_tail;
      end
      default: ;
    endcase
    if (!seen) begin
      hb_on = 1'b0;
      pb_on = 1'b0;
      ob_on = 1'b0;
      dm_on = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hblk_n  <= 1'b1;
      pblk_n  <= 1'b1;
      clpob_n <= 1'b1;
      clpdm_n <= 1'b1;
      seq_o   <= SEQ_BLANK;
    end else begin
      hblk_n  <= !hb_on;
      pblk_n  <= !pb_on;
      clpob_n <= !ob_on;
      clpdm_n <= !dm_on;
      seq_o   <= seen ? seq : SEQ_BLANK;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hblk_n && pblk_n && clpob_n && clpdm_n && seq_o == SEQ_BLANK));

  assert_dummy_hblk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && px < dummy_px) |=> !hblk_n);

  assert_blank_no_clpob_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SEQ_BLANK) |=> clpob_n);

  assert_blank_dm_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SEQ_BLANK && !blank_clpdm) |=> clpdm_n);

  assert_ob_clamps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && seq == SEQ_OB && px < line_px) |=> (!clpob_n && !clpdm_n));

  assert_image_end_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SEQ_IMAGE && px >= line_px) |=> (clpob_n && clpdm_n));
endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [PIX_W-1:0]  cfg_dummy_px,
  input  logic [PIX_W-1:0]  cfg_line_px,
  input  logic [PIX_W-1:0]  cfg_tail_ob_px,
  input  logic [LINE_W-1:0] cfg_vblank_lines,
  input  logic [LINE_W-1:0] cfg_front_ob_lines,
  input  logic [LINE_W-1:0] cfg_active_lines,
  input  logic [LINE_W-1:0] cfg_back_ob_lines,
  input  logic              cfg_blank_clpdm,
  input  logic              cfg_blank_pblk,
  output logic              hblk_n,
  output logic              pblk_n,
  output logic              clpob_n,
  output logic              clpdm_n,
  output logic [1:0]        seq_code
);
  logic [PIX_W-1:0]  px_nxt;
  logic [LINE_W-1:0] line_nxt;
  logic              seen_nxt;
  seq_e              seq_nxt;
  seq_e              seq_q;

  ccd_pos_counter #(.PIX_W(PIX_W), .LINE_W(LINE_W)) pos_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_start  (line_start),
    .px_nxt      (px_nxt),
    .line_nxt    (line_nxt),
    .seen_nxt    (seen_nxt)
  );

  ccd_region_decode #(.LINE_W(LINE_W)) region_i (
    .line_idx       (line_nxt),
    .seen           (seen_nxt),
    .vblank_lines   (cfg_vblank_lines),
    .front_ob_lines (cfg_front_ob_lines),
    .active_lines   (cfg_active_lines),
    .back_ob_lines  (cfg_back_ob_lines),
    .seq            (seq_nxt)
  );

  ccd_strobe_gen #(.PIX_W(PIX_W)) strobe_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .px          (px_nxt),
    .seen        (seen_nxt),
    .seq         (seq_nxt),
    .dummy_px    (cfg_dummy_px),
    .line_px     (cfg_line_px),
    .tail_px     (cfg_tail_ob_px),
    .blank_clpdm (cfg_blank_clpdm),
    .blank_pblk  (cfg_blank_pblk),
    .hblk_n      (hblk_n),
    .pblk_n      (pblk_n),
    .clpob_n     (clpob_n),
    .clpdm_n     (clpdm_n),
    .seq_o       (seq_q)
  );

  assign seq_code = seq_q;

  assert_seq_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_code != 2'b11);

  assert_frame_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_vblank_lines != '0) |=> (seq_code == 2'b00));
endmodule

// File: tb/ccd_line_sequencer_tb_top.sv
module ccd_line_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 12;
  localparam int LINE_W     = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic line_start = 1'b0;
  logic [PIX_W-1:0]  cfg_dummy_px, cfg_line_px, cfg_tail_ob_px;
  logic [LINE_W-1:0] cfg_vblank_lines, cfg_front_ob_lines, cfg_active_lines, cfg_back_ob_lines;
  logic cfg_blank_clpdm = 1'b0;
  logic cfg_blank_pblk = 1'b0;
  logic hblk_n, pblk_n, clpob_n, clpdm_n;
  logic [1:0] seq_code;

  int checks = 0;
  int errors = 0;
  int c_d, c_l, c_t, c_vb, c_fo, c_ac, c_bo;
  int m_px = 0;
  int m_line = 0;
  bit m_seen = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_line_sequencer #(.PIX_W(PIX_W), .LINE_W(LINE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .cfg_dummy_px(cfg_dummy_px), .cfg_line_px(cfg_line_px), .cfg_tail_ob_px(cfg_tail_ob_px),
    .cfg_vblank_lines(cfg_vblank_lines), .cfg_front_ob_lines(cfg_front_ob_lines),
    .cfg_active_lines(cfg_active_lines), .cfg_back_ob_lines(cfg_back_ob_lines),
    .cfg_blank_clpdm(cfg_blank_clpdm), .cfg_blank_pblk(cfg_blank_pblk),
    .hblk_n(hblk_n), .pblk_n(pblk_n), .clpob_n(clpob_n), .clpdm_n(clpdm_n),
    .seq_code(seq_code)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s line=%0d px=%0d actual=%0d expected=%0d", req, what, m_line, m_px, act, exp);
    end
  endtask

  task automatic set_cfg(input int d, input int l, input int t, input int vb,
                         input int fo, input int ac, input int bo);
    c_d = d; c_l = l; c_t = t; c_vb = vb; c_fo = fo; c_ac = ac; c_bo = bo;
    cfg_dummy_px       = PIX_W'(d);
    cfg_line_px        = PIX_W'(l);
    cfg_tail_ob_px     = PIX_W'(t);
    cfg_vblank_lines   = LINE_W'(vb);
    cfg_front_ob_lines = LINE_W'(fo);
    cfg_active_lines   = LINE_W'(ac);
    cfg_back_ob_lines  = LINE_W'(bo);
  endtask

  // Expected outputs from the requirements, from the bench's own position model
  task automatic compare_all();
    int rg;
    bit hb, inl, tail, ob, dm, pb;
    string rq;
    if (!m_seen) begin
      chk("R1", "hblk_n", int'(hblk_n), 1);
      chk("R1", "pblk_n", int'(pblk_n), 1);
      chk("R1", "clpob_n", int'(clpob_n), 1);
      chk("R1", "clpdm_n", int'(clpdm_n), 1);
      chk("R1", "seq_code", int'(seq_code), 0);
      return;
    end
    if (m_line < c_vb) rg = 0;
    else if (m_line < c_vb + c_fo) rg = 1;
    else if (m_line < c_vb + c_fo + c_ac) rg = 2;
    else if (m_line < c_vb + c_fo + c_ac + c_bo) rg = 1;
    else rg = 0;
    hb   = (m_px < c_d) || (m_px >= c_l);
    inl  = (m_px < c_l);
    tail = inl && (m_px >= c_l - c_t);
    pb = hb; ob = 1'b0; dm = 1'b0;
    if (rg == 0) begin
      dm = cfg_blank_clpdm && (m_px < c_d);
      pb = cfg_blank_pblk || hb;
      rq = "R5";
    end else if (rg == 1) begin
      ob = inl; dm = inl; rq = "R8";
    end else begin
      ob = tail; dm = tail; rq = "R9";
    end
    chk("R3", "seq_code", int'(seq_code), rg);
    chk("R2/R4", "hblk_n", int'(hblk_n), int'(!hb));
    chk("R7", "pblk_n", int'(pblk_n), int'(!pb));
    chk(rq, "clpob_n", int'(clpob_n), int'(!ob));
    chk((rg == 0) ? "R6" : rq, "clpdm_n", int'(clpdm_n), int'(!dm));
  endtask

  task automatic cyc(input bit fs, input bit ls);
    frame_start = fs;
    line_start  = ls;
    @(posedge clk);
    if (fs) begin m_px = 0; m_line = 0; m_seen = 1'b1; end
    else if (ls) begin m_px = 0; m_line++; end
    else m_px++;
    @(negedge clk);
    frame_start = 1'b0;
    line_start  = 1'b0;
    compare_all();
  endtask

  // One frame plus two trailing blanking lines; line long_ln overruns by 3 pixels
  task automatic run_frame(input int long_ln, input bit both_pulses);
    int total = c_vb + c_fo + c_ac + c_bo + 2;
    for (int ln = 0; ln < total; ln++) begin
      int len = (ln == long_ln) ? c_l + 3 : c_l;
      if (ln == 0) cyc(1'b1, both_pulses);
      else cyc(1'b0, 1'b1);
      for (int p = 1; p < len; p++) cyc(1'b0, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_cfg(3, 12, 4, 2, 2, 3, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs inactive while held in reset
    compare_all();
    rst_n = 1'b1;
    // R1: idle after reset until the first frame_start, even with line pulses
    for (int i = 0; i < 6; i++) cyc(1'b0, (i == 3));
    m_line = 0;
    // Sweep both blanking modes (R6, R7) over full frames
    for (int mode = 0; mode < 4; mode++) begin
      cfg_blank_clpdm = mode[0];
      cfg_blank_pblk  = mode[1];
      run_frame(mode + 1, 1'b0);
    end
    // R2: frame_start wins over line_start in the same cycle
    run_frame(4, 1'b1);
    // Second geometry: no leading blanking lines, different line layout
    set_cfg(2, 10, 2, 0, 1, 2, 2);
    cfg_blank_clpdm = 1'b1;
    cfg_blank_pblk  = 1'b0;
    run_frame(2, 1'b0);
    set_cfg(4, 9, 5, 1, 1, 1, 1);
    run_frame(3, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule